// File: doc/BRIEF.md
# Stacked-Board SPI Command Decoder

This block is the serial front end of one board in a stack of waveform-generator boards that share a single SPI bus. The bus master sends a command byte that names a target board (or all boards at once), says whether the access goes to a register or to a channel memory, and says whether it is a write or a read. The block then updates or returns one of three 8-bit registers, or turns the rest of the transaction into 16-bit write strobes into one of three channel memories, with the address stepping by one after each word.

The SPI pins are asynchronous to the block clock. They pass through synchronizers, and the serial clock is oversampled, so SCLK must stay well below the block clock. The configuration register drives the board controls directly: a self-clearing reset, clock doubling, playback enable, a software trigger that is merged with the external trigger pin, and a select for the auxiliary output. That output carries either the MISO stream or a masked OR of the channel activity flags.

Top module: `spi_cmd_decoder`

## Requirements
- R1: The command byte is the first byte of a transaction and is decoded as follows: bit 7 set means write, bits [6:3] give the target board, bit 2 set selects a memory access, and bits [1:0] give the register or memory number.
- R2: A command whose board field equals `board_id`, or equals 4'hF (broadcast), is accepted. Any other command leaves all registers unchanged, produces no memory write and keeps `spi_miso_oe` low until chip select rises.
- R3: A register write is the command byte plus one data byte. Register 0 is configuration, register 1 is checksum (`crc_value`) and register 2 is frame select (`frame_sel`). A write to register 3 changes nothing.
- R4: A register read is a 16-bit transfer. The selected register value (register 3 reads as 0) is shifted out MSB first during the second byte, changing on falling SCLK edges. `spi_miso_oe` is high only from the decode of an accepted read until chip select rises, and a read changes no register.
- R5: A memory write to memory 0..2 is the command byte, then the start address low byte, then the start address high byte, then 16-bit words sent high byte first. Each completed word gives a one-cycle, one-hot `mem_we` pulse for that memory, with `mem_addr` and `mem_wdata`. The address increases by one per word and wraps from 16'hFFFF to 0.
- R6: A memory write to memory 3, and any memory read command, produces no `mem_we` pulse and does not drive MISO.
- R7: Configuration bit 1 drives `cfg_clk2x` and bit 2 drives `cfg_enable`.
- R8: Writing 1 to configuration bit 0 raises `cfg_reset` for exactly one clock cycle. The bit then reads back as 0.
- R9: `trig_out` is the OR of configuration bit 3 and `ext_trig`.
- R10: When configuration bit 4 is 1, `aux_out` follows the MISO data line. When it is 0, `aux_out` is the OR over channels c of `chan_active[c]` AND configuration bit 5+c.
- R11: After reset, all registers are 0, and `mem_we`, `spi_miso_oe`, `spi_miso`, `cfg_reset` and `aux_out` are low.
- R12: Raising chip select ends the transaction. A partly received data byte or word is dropped, and the next transaction starts again at a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| board_id | input | 4 | Board number of this board (static) |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_mosi | input | 1 | SPI data from master |
| spi_miso | output | 1 | SPI data to master |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad (low = high impedance) |
| ext_trig | input | 1 | External trigger input |
| chan_active | input | 3 | Activity flag per channel |
| cfg_reset | output | 1 | Self-clearing board reset pulse |
| cfg_clk2x | output | 1 | Clock-double control |
| cfg_enable | output | 1 | Playback enable |
| trig_out | output | 1 | Combined trigger |
| aux_out | output | 1 | Auxiliary output (MISO copy or masked activity) |
| frame_sel | output | 8 | Frame select register |
| crc_value | output | 8 | Checksum register |
| mem_we | output | 3 | One-hot memory write strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory word data |

## Verification
The bench builds the block with its default two-stage synchronizer and runs SCLK at one sixteenth of the block clock, so every byte boundary and every edge-detect delay is exercised at a realistic oversampling ratio. It sweeps the whole 16-value board field against three local board numbers (0, 5 and 14). That covers match, mismatch and broadcast for both edge and interior IDs. It also sweeps all 64 combinations of mask and activity flags for the auxiliary output. Memory streams cross a carry into the high address byte and the 16-bit wrap, and truncated transactions cover the abort path.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int NUM_CH   = 3;
  localparam int BRD_W    = 4;
  localparam int WORD_W   = 16;
  localparam int MADDR_W  = 16;

  localparam logic [BRD_W-1:0] BCAST_ID = 4'hF;

  localparam logic [1:0] RA_CFG = 2'd0;
  localparam logic [1:0] RA_CRC = 2'd1;
  localparam logic [1:0] RA_FRM = 2'd2;

  localparam int CB_RST   = 0;
  localparam int CB_CLK2X = 1;
  localparam int CB_EN    = 2;
  localparam int CB_TRIG  = 3;
  localparam int CB_AUX   = 4;
  localparam int CB_MASK  = 5;

  typedef struct packed {
    logic             wr;
    logic [BRD_W-1:0] brd;
    logic             mem;
    logic [1:0]       sel;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_REG_WR,
    ST_REG_RD,
    ST_ADR_LO,
    ST_ADR_HI,
    ST_DAT_HI,
    ST_DAT_LO,
    ST_SKIP
  } eng_state_t;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_raw,
  input  logic sclk_raw,
  input  logic mosi_raw,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] csn_p, sclk_p, mosi_p;
  logic [LAST:0] csn_pn, sclk_pn, mosi_pn;
  logic          sclk_d;

  // each chain shifts the raw input in at bit 0
  always_comb begin
    csn_pn  = {csn_p[LAST-1:0],  csn_raw};
    sclk_pn = {sclk_p[LAST-1:0], sclk_raw};
    mosi_pn = {mosi_p[LAST-1:0], mosi_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_p  <= '1;
      sclk_p <= '0;
      mosi_p <= '0;
      sclk_d <= 1'b0;
    end else begin
      csn_p  <= csn_pn;
      sclk_p <= sclk_pn;
      mosi_p <= mosi_pn;
      sclk_d <= sclk_p[LAST];
    end
  end

  assign cs_act    = ~csn_p[LAST];
  assign sclk_rise =  sclk_p[LAST] & ~sclk_d;
  assign sclk_fall = ~sclk_p[LAST] &  sclk_d;
  assign mosi_s    =  mosi_p[LAST];

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       mosi_s,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       miso
);

  logic [2:0] bit_q,  bit_n;
  logic [7:0] rxsr_q, rxsr_n;
  logic [7:0] txsr_q, txsr_n;
  logic [7:0] rxb_q,  rxb_n;
  logic       vld_q,  vld_n;
  logic       miso_q, miso_n;
  logic [7:0] rx_shift;

  assign rx_shift = {rxsr_q[6:0], mosi_s};

  always_comb begin
    bit_n  = bit_q;
    rxsr_n = rxsr_q;
    txsr_n = txsr_q;
    rxb_n  = rxb_q;
    vld_n  = 1'b0;
    miso_n = miso_q;
    if (!cs_act) begin
      bit_n  = '0;
      txsr_n = '0;
      miso_n = 1'b0;
    end else begin
      if (sclk_rise) begin
        rxsr_n = rx_shift;
        bit_n  = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          vld_n = 1'b1;
          rxb_n = rx_shift;
        end
      end
      if (tx_load) begin
        txsr_n = tx_byte;
      end else if (sclk_fall) begin
        miso_n = txsr_q[7];
        txsr_n = {txsr_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rxsr_q <= '0;
      txsr_q <= '0;
      rxb_q  <= '0;
      vld_q  <= 1'b0;
      miso_q <= 1'b0;
    end else begin
      bit_q  <= bit_n;
      rxsr_q <= rxsr_n;
      txsr_q <= txsr_n;
      rxb_q  <= rxb_n;
      vld_q  <= vld_n;
      miso_q <= miso_n;
    end
  end

  assign rx_valid = vld_q;
  assign rx_byte  = rxb_q;
  assign miso     = miso_q;

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_act,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  input  logic [BRD_W-1:0]     board_id,
  output logic                 tx_load,
  output logic [7:0]           tx_byte,
  output logic                 miso_oe,
  output logic [7:0]           cfg,
  output logic [7:0]           frm,
  output logic [7:0]           crc,
  output logic [NUM_CH-1:0]    mem_we,
  output logic [MADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]    mem_wdata
);

  eng_state_t         st_q, st_n;
  logic [7:0]         adlo_q, adlo_n;
  logic [MADDR_W-1:0] ptr_q, ptr_n;
  logic [7:0]         hi_q, hi_n;
  logic [1:0]         sel_q, sel_n;
  logic [7:0]         cfg_q, cfg_n, frm_q, frm_n, crc_q, crc_n;
  logic [NUM_CH-1:0]  we_q, we_n;
  logic [MADDR_W-1:0] wa_q, wa_n;
  logic [WORD_W-1:0]  wd_q, wd_n;
  logic               ld_q, ld_n;
  logic [7:0]         txb_q, txb_n;
  logic               oe_q, oe_n;

  cmd_t cmd;
  logic hit;
  logic [7:0] rd_val;

  assign cmd = cmd_t'(rx_byte);
  assign hit = (cmd.brd == board_id) || (cmd.brd == BCAST_ID);

  always_comb begin
    unique case (cmd.sel)
      RA_CFG:  rd_val = cfg_q;
      RA_CRC:  rd_val = crc_q;
      RA_FRM:  rd_val = frm_q;
      default: rd_val = 8'h00;
    endcase
  end

  always_comb begin
    st_n   = st_q;
    adlo_n = adlo_q;
    ptr_n  = ptr_q;
    hi_n   = hi_q;
    sel_n  = sel_q;
    cfg_n  = cfg_q;
    cfg_n[CB_RST] = 1'b0;
    frm_n  = frm_q;
    crc_n  = crc_q;
    we_n   = '0;
    wa_n   = wa_q;
    wd_n   = wd_q;
    ld_n   = 1'b0;
    txb_n  = txb_q;
    oe_n   = oe_q;
    if (!cs_act) begin
      st_n = ST_CMD;
      oe_n = 1'b0;
    end else if (rx_valid) begin
      unique case (st_q)
        ST_CMD: begin
          sel_n = cmd.sel;
          if (!hit) begin
            st_n = ST_SKIP;
          end else if (cmd.mem) begin
            st_n = cmd.wr ? ST_ADR_LO : ST_SKIP;
          end else if (cmd.wr) begin
            st_n = ST_REG_WR;
          end else begin
            st_n  = ST_REG_RD;
            ld_n  = 1'b1;
            txb_n = rd_val;
            oe_n  = 1'b1;
          end
        end
        ST_REG_WR: begin
          st_n = ST_SKIP;
          unique case (sel_q)
            RA_CFG:  cfg_n = rx_byte;
            RA_CRC:  crc_n = rx_byte;
            RA_FRM:  frm_n = rx_byte;
            default: ;
          endcase
        end
        ST_ADR_LO: begin
          adlo_n = rx_byte;
          st_n   = ST_ADR_HI;
        end
        ST_ADR_HI: begin
          ptr_n = {rx_byte, adlo_q};
          st_n  = ST_DAT_HI;
        end
        ST_DAT_HI: begin
          hi_n = rx_byte;
          st_n = ST_DAT_LO;
        end
        ST_DAT_LO: begin
          for (int c = 0; c < NUM_CH; c++) begin
            if (sel_q == c[1:0]) we_n[c] = 1'b1;
          end
          wa_n  = ptr_q;
          wd_n  = {hi_q, rx_byte};
          ptr_n = ptr_q + 1'b1;
          st_n  = ST_DAT_HI;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CMD;
      adlo_q <= '0;
      ptr_q  <= '0;
      hi_q   <= '0;
      sel_q  <= '0;
      cfg_q  <= '0;
      frm_q  <= '0;
      crc_q  <= '0;
      we_q   <= '0;
      wa_q   <= '0;
      wd_q   <= '0;
      ld_q   <= 1'b0;
      txb_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      adlo_q <= adlo_n;
      ptr_q  <= ptr_n;
      hi_q   <= hi_n;
      sel_q  <= sel_n;
      cfg_q  <= cfg_n;
      frm_q  <= frm_n;
      crc_q  <= crc_n;
      we_q   <= we_n;
      wa_q   <= wa_n;
      wd_q   <= wd_n;
      ld_q   <= ld_n;
      txb_q  <= txb_n;
      oe_q   <= oe_n;
    end
  end

  assign tx_load   = ld_q;
  assign tx_byte   = txb_q;
  assign miso_oe   = oe_q;
  assign cfg       = cfg_q;
  assign frm       = frm_q;
  assign crc       = crc_q;
  assign mem_we    = we_q;
  assign mem_addr  = wa_q;
  assign mem_wdata = wd_q;

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BRD_W-1:0]     board_id,
  input  logic                 spi_csn,
  input  logic                 spi_sclk,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  output logic                 spi_miso_oe,
  input  logic                 ext_trig,
  input  logic [NUM_CH-1:0]    chan_active,
  output logic                 cfg_reset,
  output logic                 cfg_clk2x,
  output logic                 cfg_enable,
  output logic                 trig_out,
  output logic                 aux_out,
  output logic [7:0]           frame_sel,
  output logic [7:0]           crc_value,
  output logic [NUM_CH-1:0]    mem_we,
  output logic [MADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]    mem_wdata
);

  logic       cs_act, sclk_rise, sclk_fall, mosi_s;
  logic       rx_valid, tx_load, miso_bit;
  logic [7:0] rx_byte, tx_byte, cfg;
  logic [NUM_CH-1:0] act_masked;

  spi_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn_raw   (spi_csn),
    .sclk_raw  (spi_sclk),
    .mosi_raw  (spi_mosi),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s)
  );

  spi_cmd_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .miso      (miso_bit)
  );

  spi_cmd_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .board_id  (board_id),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .miso_oe   (spi_miso_oe),
    .cfg       (cfg),
    .frm       (frame_sel),
    .crc       (crc_value),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // per-channel masking of activity flags for the auxiliary pin
  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign act_masked[c] = chan_active[c] & cfg[CB_MASK + c];
  end

  assign spi_miso   = miso_bit;
  assign cfg_reset  = cfg[CB_RST];
  assign cfg_clk2x  = cfg[CB_CLK2X];
  assign cfg_enable = cfg[CB_EN];
  assign trig_out   = cfg[CB_TRIG] | ext_trig;
  assign aux_out    = cfg[CB_AUX] ? miso_bit : |act_masked;

endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk
  import spi_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic [NUM_CH-1:0] mem_we,
  input logic              spi_miso_oe,
  input logic              cfg_reset,
  input logic              ext_trig,
  input logic              trig_out
);

  // R5: at most one memory strobe at a time
  a_r5_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_we));

  // R5 / R12: a strobe only follows a cycle inside a transaction
  a_r5_we_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> $past(cs_act));

  // R4: MISO drive released once chip select is seen high
  a_r4_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso_oe);

  // R8: reset control lasts a single cycle
  a_r8_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |=> !cfg_reset);

  // R9: external trigger always reaches the combined trigger
  a_r9_trig_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trig |-> trig_out);

endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk u_chk (.*);

// File: tb/spi_cmd_decoder_bench.sv
`timescale 1ns/1ps
module spi_cmd_decoder_bench;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  board_id;
  logic        spi_csn, spi_sclk, spi_mosi;
  logic        spi_miso, spi_miso_oe;
  logic        ext_trig;
  logic [2:0]  chan_active;
  logic        cfg_reset, cfg_clk2x, cfg_enable, trig_out, aux_out;
  logic [7:0]  frame_sel, crc_value;
  logic [2:0]  mem_we;
  logic [15:0] mem_addr, mem_wdata;

  always #2.5 clk = ~clk;

  spi_cmd_decoder u_spi_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .board_id(board_id),
    .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .ext_trig(ext_trig), .chan_active(chan_active),
    .cfg_reset(cfg_reset), .cfg_clk2x(cfg_clk2x), .cfg_enable(cfg_enable),
    .trig_out(trig_out), .aux_out(aux_out),
    .frame_sel(frame_sel), .crc_value(crc_value),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int nchk = 0;
  int nfail = 0;

  // memory strobe capture and reset-pulse width counter
  int          cap_n = 0;
  logic [2:0]  cap_we [256];
  logic [15:0] cap_a  [256];
  logic [15:0] cap_d  [256];
  int          rst_cycles = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && (|mem_we) && cap_n < 256) begin
      cap_we[cap_n] = mem_we;
      cap_a[cap_n]  = mem_addr;
      cap_d[cap_n]  = mem_wdata;
      cap_n = cap_n + 1;
    end
    if (rst_n === 1'b1 && cfg_reset === 1'b1) rst_cycles = rst_cycles + 1;
  end

  logic [7:0]  txb [16];
  logic [7:0]  rx_last, aux_last;
  logic        oe_any, oe_all;
  logic [15:0] wbuf [8];

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input int n);
    rx_last = 8'h00; aux_last = 8'h00; oe_any = 1'b0; oe_all = 1'b1;
    spi_csn = 1'b0;
    wt(HALF);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        spi_mosi = txb[i][b];
        wt(HALF);
        spi_sclk = 1'b1;
        if (i == n - 1) begin
          rx_last  = {rx_last[6:0], spi_miso};
          aux_last = {aux_last[6:0], aux_out};
        end
        if (i > 0) oe_all = oe_all & spi_miso_oe;
        oe_any = oe_any | spi_miso_oe;
        wt(HALF);
        spi_sclk = 1'b0;
      end
    end
    wt(HALF);
    spi_csn = 1'b1;
    wt(12);
  endtask

  task automatic wr_reg(input logic [3:0] brd, input logic [1:0] a, input logic [7:0] d);
    txb[0] = {1'b1, brd, 1'b0, a};
    txb[1] = d;
    xfer(2);
  endtask

  task automatic rd_reg(input logic [3:0] brd, input logic [1:0] a);
    txb[0] = {1'b0, brd, 1'b0, a};
    txb[1] = 8'hA5;
    xfer(2);
  endtask

  task automatic wr_mem(input logic [3:0] brd, input logic [1:0] ch,
                        input logic [15:0] adr, input int nw);
    txb[0] = {1'b1, brd, 1'b1, ch};
    txb[1] = adr[7:0];
    txb[2] = adr[15:8];
    for (int w = 0; w < nw; w++) begin
      txb[3 + 2*w] = wbuf[w][15:8];
      txb[4 + 2*w] = wbuf[w][7:0];
    end
    xfer(3 + 2*nw);
  endtask

  task automatic chk_cap(input string req, input int idx, input int ch,
                         input logic [15:0] a, input logic [15:0] d);
    chk(req, "strobe", {29'd0, cap_we[idx]}, 32'd1 << ch);
    chk(req, "addr",   {16'd0, cap_a[idx]}, {16'd0, a});
    chk(req, "data",   {16'd0, cap_d[idx]}, {16'd0, d});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail = nfail + 1;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] prev, val;
    logic [3:0] ids [3];
    rst_n = 1'b0; spi_csn = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
    board_id = 4'd5; ext_trig = 1'b0; chan_active = 3'b000;
    wt(5);
    rst_n = 1'b1;
    wt(5);

    // R11 reset state
    chk("R11", "frame_sel", {24'd0, frame_sel}, 0);
    chk("R11", "crc_value", {24'd0, crc_value}, 0);
    chk("R11", "cfg outs", {29'd0, cfg_reset, cfg_clk2x, cfg_enable}, 0);
    chk("R11", "mem_we/oe/miso/aux", {27'd0, mem_we, spi_miso_oe, spi_miso, aux_out}, 0);
    chk("R11", "trig_out", {31'd0, trig_out}, 0);

    // R1 R2: board field sweep against three local IDs
    ids[0] = 4'd0; ids[1] = 4'd5; ids[2] = 4'd14;
    base = cap_n;
    for (int k = 0; k < 3; k++) begin
      board_id = ids[k];
      for (int b = 0; b < 16; b++) begin
        prev = frame_sel;
        val  = 8'(k * 16 + b + 1);
        wr_reg(4'(b), 2'd2, val);
        chk("R2", "frame after addressed write", {24'd0, frame_sel},
            {24'd0, ((b == ids[k]) || (b == 15)) ? val : prev});
      end
    end
    chk("R1", "no memory strobe from register writes", cap_n - base, 0);
    board_id = 4'd5;

    // R3 register map, R7 controls
    wr_reg(4'd5, 2'd0, 8'h06);
    chk("R7", "clk2x", {31'd0, cfg_clk2x}, 1);
    chk("R7", "enable", {31'd0, cfg_enable}, 1);
    wr_reg(4'd5, 2'd1, 8'hC3);
    chk("R3", "checksum reg", {24'd0, crc_value}, 32'hC3);
    wr_reg(4'd15, 2'd2, 8'h3C);
    chk("R3", "frame reg", {24'd0, frame_sel}, 32'h3C);
    wr_reg(4'd5, 2'd3, 8'hFF);
    chk("R3", "reg3 write ignored", {16'd0, frame_sel, crc_value}, 32'h3CC3);
    chk("R3", "reg3 write cfg", {30'd0, cfg_clk2x, cfg_enable}, 32'h3);
    wr_reg(4'd5, 2'd0, 8'h02);
    chk("R7", "enable cleared", {30'd0, cfg_clk2x, cfg_enable}, 32'h2);
    wr_reg(4'd5, 2'd0, 8'h06);

    // R4 reads
    rd_reg(4'd5, 2'd1);
    chk("R4", "read checksum", {24'd0, rx_last}, 32'hC3);
    chk("R4", "oe in data byte", {31'd0, oe_all}, 1);
    chk("R4", "oe after cs high", {31'd0, spi_miso_oe}, 0);
    rd_reg(4'd5, 2'd2);
    chk("R4", "read frame", {24'd0, rx_last}, 32'h3C);
    rd_reg(4'd15, 2'd0);
    chk("R4", "broadcast read config", {24'd0, rx_last}, 32'h06);
    rd_reg(4'd5, 2'd3);
    chk("R4", "read reg3", {24'd0, rx_last}, 0);
    rd_reg(4'd6, 2'd1);
    chk("R2", "mismatched read keeps MISO off", {31'd0, oe_any}, 0);
    chk("R4", "read leaves regs", {16'd0, frame_sel, crc_value}, 32'h3CC3);

    // R8 self-clearing reset
    base = rst_cycles;
    wr_reg(4'd5, 2'd0, 8'h07);
    chk("R8", "reset high cycles", rst_cycles - base, 1);
    rd_reg(4'd5, 2'd0);
    chk("R8", "reset bit reads 0", {24'd0, rx_last}, 32'h06);

    // R9 trigger sweep
    for (int s = 0; s < 2; s++) begin
      wr_reg(4'd5, 2'd0, s[0] ? 8'h0C : 8'h04);
      for (int e = 0; e < 2; e++) begin
        ext_trig = e[0];
        wt(1);
        chk("R9", "trigger OR", {31'd0, trig_out}, {31'd0, s[0] | e[0]});
      end
    end
    ext_trig = 1'b0;

    // R10 mask x activity sweep
    for (int m = 0; m < 8; m++) begin
      wr_reg(4'd5, 2'd0, {m[2:0], 5'b00100});
      for (int a = 0; a < 8; a++) begin
        chan_active = a[2:0];
        wt(1);
        chk("R10", "masked activity", {31'd0, aux_out}, {31'd0, |(m[2:0] & a[2:0])});
      end
    end
    chan_active = 3'b111;
    wr_reg(4'd5, 2'd0, 8'h14);
    wt(2);
    chk("R10", "aux follows idle MISO", {31'd0, aux_out}, 0);
    rd_reg(4'd5, 2'd1);
    chk("R10", "aux mirrors read data", {24'd0, aux_last}, 32'hC3);
    chan_active = 3'b000;

    // R5 memory stream with carry into high address byte
    base = cap_n;
    wbuf[0] = 16'hA55A; wbuf[1] = 16'h0102; wbuf[2] = 16'hFFFF;
    wr_mem(4'd5, 2'd1, 16'h12FE, 3);
    chk("R5", "word count", cap_n - base, 3);
    chk_cap("R5", base,     1, 16'h12FE, 16'hA55A);
    chk_cap("R5", base + 1, 1, 16'h12FF, 16'h0102);
    chk_cap("R5", base + 2, 1, 16'h1300, 16'hFFFF);
    // all channels, broadcast, wrap at top of address space
    for (int c = 0; c < 3; c++) begin
      base = cap_n;
      wbuf[0] = 16'(16'h1111 * (c + 1)); wbuf[1] = 16'(16'h8000 + c);
      wr_mem((c == 1) ? 4'd15 : 4'd5, 2'(c), 16'hFFFF, 2);
      chk("R5", "word count per channel", cap_n - base, 2);
      chk_cap("R5", base,     c, 16'hFFFF, 16'(16'h1111 * (c + 1)));
      chk_cap("R5", base + 1, c, 16'h0000, 16'(16'h8000 + c));
    end

    // R6 memory 3 and memory read ignored; R2 mismatched memory write
    base = cap_n;
    wbuf[0] = 16'h1234;
    wr_mem(4'd5, 2'd3, 16'h0010, 1);
    chk("R6", "memory 3 no strobe", cap_n - base, 0);
    txb[0] = {1'b0, 4'd5, 1'b1, 2'd0}; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
    xfer(4);
    chk("R6", "memory read no strobe", cap_n - base, 0);
    chk("R6", "memory read no MISO drive", {31'd0, oe_any}, 0);
    wr_mem(4'd9, 2'd0, 16'h0010, 1);
    chk("R2", "mismatched memory write", cap_n - base, 0);

    // R12 aborted transactions
    txb[0] = {1'b1, 4'd5, 1'b1, 2'd2}; txb[1] = 8'h20; txb[2] = 8'h00; txb[3] = 8'hAB;
    xfer(4);
    chk("R12", "half word dropped", cap_n - base, 0);
    txb[0] = {1'b1, 4'd5, 1'b0, 2'd2};
    xfer(1);
    chk("R12", "write without data byte", {24'd0, frame_sel}, 32'h3C);
    wr_reg(4'd5, 2'd2, 8'h77);
    chk("R12", "next transaction decodes command", {24'd0, frame_sel}, 32'h77);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule